// File: doc/BRIEF.md
# Combined-Source Interrupt Request Controller

This block merges several peripheral request sources into one maskable interrupt request to the CPU. Each source raises a one-cycle event pulse that sets its bit in a status register. Software owns a matching enable register. The pending flag is a plain level: it is 1 exactly while some status bit and its enable bit are both 1. It is not latched, software cannot write it, and acknowledging the interrupt does not clear it. The handler reads the status register to find the active source, then clears that status bit by writing 0 to it.

The pending flag passes through a priority gate before it reaches the CPU. The gate uses three inputs: the global interrupt-enable from the CPU, a 3-bit level field held in the control register, and the processor's current priority level. The request output is registered.

All software access goes through a plain register port. A write takes effect at the clock edge. A read is combinational from the address. There is no streaming data path, so the port has no valid/ready handshake.

Top module: `merged_irq_ctrl`

Register map (address on `reg_addr`):
- 0: status. On a read, bit i is the status of source i. On a write, a 0 in data bit i clears status bit i, and a 1 leaves that bit unchanged.
- 1: enable. Bit i enables source i. Readable and writable.
- 2: control. Bits [2:0] hold the level field, readable and writable. Bit 3 reads back the pending flag and ignores writes.

## Requirements
- R1: After reset, the status, enable and level registers read 0, the pending flag reads 0, and `irq_req` is 0.
- R2: An event pulse on `src_evt[i]` sets status bit i at the next clock edge. The bit then stays 1 until software clears it.
- R3: A write to address 0 clears each status bit whose data bit is 0. A data bit of 1 leaves its status bit unchanged.
- R4: If an event on a source arrives in the same cycle as a software clear of that source's bit, the event wins and the bit stays 1.
- R5: The pending flag (control bit 3) is 1 whenever at least one source has both its status bit and its enable bit at 1. The flag stays 1 while further enabled sources arrive. It drops to 0 as soon as no such source remains, even if the interrupt was never acknowledged.
- R6: A write to control bit 3 has no effect on the pending flag.
- R7: `irq_ack` changes neither the status bits, nor the pending flag, nor `irq_req`.
- R8: `irq_req` is 1 in the cycle after the one in which all three of these hold: the pending flag is 1, `cpu_ie` is 1, and the level field is strictly greater than `cpu_ipl`. Otherwise it is 0. An event therefore raises `irq_req` two clock edges after it is sampled.
- R9: A level field of 0 never produces a request, whatever `cpu_ipl` and `cpu_ie` are.
- R10: Writes to the enable register and the level field read back unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_evt | input | N_SRC | One-cycle event pulses, one bit per source |
| reg_addr | input | 2 | Register address |
| reg_we | input | 1 | Write strobe |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data |
| cpu_ie | input | 1 | Global interrupt-enable flag from the CPU |
| cpu_ipl | input | LVL_W | Current processor priority level |
| irq_ack | input | 1 | Interrupt acknowledge from the CPU |
| irq_req | output | 1 | Registered interrupt request to the CPU |

## Verification
The bench builds the block with its defaults: four sources, an 8-bit data path and a 3-bit level. With four sources it can keep one source disabled while two enabled ones overlap. That brings within reach a pending flag that stays high across overlapping sources and drops only when the last enabled source is cleared. With a 3-bit level it can test both the strict level-above-priority comparison at the equal point and a level of zero.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_ENABLE = 2'd1,
    REG_CTRL   = 2'd2,
    REG_NONE   = 2'd3
  } reg_sel_e;

  localparam int PEND_BIT = 3;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int N_SRC = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] evt,
  input  logic             st_we,
  input  logic [N_SRC-1:0] st_wdata,
  input  logic             en_we,
  input  logic [N_SRC-1:0] en_wdata,
  output logic [N_SRC-1:0] status,
  output logic [N_SRC-1:0] enable,
  output logic             pend
);
  logic [N_SRC-1:0] clr_mask;

  assign clr_mask = st_we ? ~st_wdata : '0;

  generate
    for (genvar i = 0; i < N_SRC; i++) begin : g_src
      always_ff @(posedge clk) begin
        if (rst) status[i] <= 1'b0;
        else     status[i] <= (status[i] & ~clr_mask[i]) | evt[i];
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)        enable <= '0;
    else if (en_we) enable <= en_wdata;
  end

  assign pend = |(status & enable);

  AST_EVT_SETS: assert property (@(posedge clk) disable iff (rst)
    (evt != '0) |=> ((status & $past(evt)) == $past(evt))); // R4

  AST_NO_SPONT_SET: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((status & ~$past(status) & ~$past(evt)) == '0)); // R3
endmodule

// File: rtl/irq_prio_gate.sv
module irq_prio_gate #(
  parameter int LVL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             pend,
  input  logic             ie,
  input  logic [LVL_W-1:0] lvl,
  input  logic [LVL_W-1:0] ipl,
  output logic             req
);
  logic pass;

  assign pass = pend & ie & (lvl > ipl);

  always_ff @(posedge clk) begin
    if (rst) req <= 1'b0;
    else     req <= pass;
  end

  AST_LVL0_QUIET: assert property (@(posedge clk) disable iff (rst)
    (lvl == '0) |=> !req); // R9

  AST_REQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    !pend |=> !req); // R8
endmodule

// File: rtl/merged_irq_ctrl.sv
module merged_irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int N_SRC  = 4,
  parameter int DATA_W = 8,
  parameter int LVL_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_evt,
  input  logic [1:0]        reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cpu_ie,
  input  logic [LVL_W-1:0]  cpu_ipl,
  input  logic              irq_ack,
  output logic              irq_req
);
  logic [N_SRC-1:0] status, enable;
  logic [LVL_W-1:0] lvl_q;
  logic             pend;
  reg_sel_e         sel;

  assign sel = reg_sel_e'(reg_addr);

  irq_src_bank #(.N_SRC(N_SRC)) u_bank (
    .clk      (clk),
    .rst      (rst),
    .evt      (src_evt),
    .st_we    (reg_we && sel == REG_STATUS),
    .st_wdata (reg_wdata[N_SRC-1:0]),
    .en_we    (reg_we && sel == REG_ENABLE),
    .en_wdata (reg_wdata[N_SRC-1:0]),
    .status   (status),
    .enable   (enable),
    .pend     (pend)
  );

  always_ff @(posedge clk) begin
    if (rst)                         lvl_q <= '0;
    else if (reg_we && sel == REG_CTRL) lvl_q <= reg_wdata[LVL_W-1:0];
  end

  irq_prio_gate #(.LVL_W(LVL_W)) u_gate (
    .clk  (clk),
    .rst  (rst),
    .pend (pend),
    .ie   (cpu_ie),
    .lvl  (lvl_q),
    .ipl  (cpu_ipl),
    .req  (irq_req)
  );

  always_comb begin
    reg_rdata = '0;
    case (sel)
      REG_STATUS: reg_rdata[N_SRC-1:0] = status;
      REG_ENABLE: reg_rdata[N_SRC-1:0] = enable;
      REG_CTRL: begin
        reg_rdata[LVL_W-1:0] = lvl_q;
        reg_rdata[PEND_BIT]  = pend;
      end
      default: reg_rdata = '0;
    endcase
  end

  AST_ACK_KEEPS_STATUS: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && !reg_we && src_evt == '0) |=> $stable(status)); // R7

  AST_ACK_KEEPS_REQ: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_req && pend && cpu_ie && lvl_q > cpu_ipl) |=> irq_req); // R7
endmodule

// File: tb/test_merged_irq_ctrl.sv
module test_merged_irq_ctrl;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] src_evt;
  logic [1:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;
  logic       cpu_ie;
  logic [2:0] cpu_ipl;
  logic       irq_ack, irq_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  merged_irq_ctrl i_merged_irq_ctrl (
    .clk(clk), .rst(rst), .src_evt(src_evt), .reg_addr(reg_addr),
    .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .cpu_ie(cpu_ie), .cpu_ipl(cpu_ipl), .irq_ack(irq_ack), .irq_req(irq_req)
  );

  // {evt[3:0], we, addr[1:0], wdata[7:0], ack, exp_status[3:0], exp_pend}
  localparam logic [20:0] VEC [11] = '{
    {4'b0010, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0010, 1'b0}, // R2 disabled source
    {4'b0001, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0011, 1'b1}, // R5 enabled source
    {4'b0000, 1'b0, 2'd0, 8'h00, 1'b1, 4'b0011, 1'b1}, // R7 ack
    {4'b0100, 1'b0, 2'd0, 8'h00, 1'b0, 4'b0111, 1'b1}, // R5 second source
    {4'b0000, 1'b1, 2'd0, 8'hFF, 1'b0, 4'b0111, 1'b1}, // R3 write ones
    {4'b0000, 1'b1, 2'd0, 8'hFE, 1'b0, 4'b0110, 1'b1}, // R3 clear bit0
    {4'b0100, 1'b1, 2'd0, 8'hFB, 1'b0, 4'b0110, 1'b1}, // R4 event wins
    {4'b0000, 1'b1, 2'd0, 8'hFB, 1'b0, 4'b0010, 1'b0}, // R5 drop unserviced
    {4'b0000, 1'b1, 2'd1, 8'h02, 1'b0, 4'b0010, 1'b1}, // R5 enable change
    {4'b0000, 1'b1, 2'd1, 8'h00, 1'b0, 4'b0010, 1'b0}, // R5 disable
    {4'b0000, 1'b1, 2'd2, 8'h0B, 1'b0, 4'b0010, 1'b0}  // R6 pend write ignored
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    src_evt = '0; reg_we = 0; reg_wdata = '0; irq_ack = 0; reg_addr = 2'd0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1; reg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    idle(); cpu_ie = 0; cpu_ipl = '0; rst = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;

    // R1 reset state
    rd(2'd0, d); check("R1 status", d, 8'h00);
    rd(2'd1, d); check("R1 enable", d, 8'h00);
    rd(2'd2, d); check("R1 ctrl", d, 8'h00);
    check("R1 irq_req", {7'b0, irq_req}, 8'h00);

    wr(2'd1, 8'h05);
    wr(2'd2, 8'h03);
    rd(2'd1, d); check("R10 enable readback", d, 8'h05);
    rd(2'd2, d); check("R10 level readback", d, 8'h03);

    for (int i = 0; i < 11; i++) begin
      logic [20:0] v;
      v = VEC[i];
      @(negedge clk);
      src_evt = v[20:17]; reg_we = v[16]; reg_addr = v[15:14];
      reg_wdata = v[13:6]; irq_ack = v[5];
      @(negedge clk);
      idle();
      rd(2'd0, d); check($sformatf("R2/R3/R4 vec %0d status", i), d, {4'b0, v[4:1]});
      rd(2'd2, d); check($sformatf("R5/R6/R7 vec %0d pend", i), {7'b0, d[3]}, {7'b0, v[0]});
    end

    // R6: level field took 3 from the write of 0x0B, pend bit ignored
    rd(2'd2, d); check("R6 ctrl after write", d, 8'h03);

    // clean slate: clear status, enable source 0
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h01);
    cpu_ie = 1; cpu_ipl = 3'd1;

    // R8 latency: event at edge A sets status, req at edge B
    @(negedge clk); src_evt = 4'b0001;
    @(negedge clk); src_evt = '0;
    check("R8 req not yet", {7'b0, irq_req}, 8'h00);
    @(negedge clk);
    check("R8 req asserted", {7'b0, irq_req}, 8'h01);

    // R7 ack leaves req high
    irq_ack = 1;
    @(negedge clk); irq_ack = 0;
    @(negedge clk);
    check("R7 req after ack", {7'b0, irq_req}, 8'h01);

    // R8 level equal to priority: no request
    cpu_ipl = 3'd3;
    @(negedge clk); @(negedge clk);
    check("R8 lvl==ipl", {7'b0, irq_req}, 8'h00);

    // R8 global enable off
    cpu_ipl = 3'd0; cpu_ie = 0;
    @(negedge clk); @(negedge clk);
    check("R8 ie off", {7'b0, irq_req}, 8'h00);
    cpu_ie = 1;
    @(negedge clk); @(negedge clk);
    check("R8 ie on", {7'b0, irq_req}, 8'h01);

    // R9 level zero blocks even with ipl 0
    wr(2'd2, 8'h00);
    @(negedge clk);
    check("R9 level zero", {7'b0, irq_req}, 8'h00);

    // R5 clear source: req falls
    wr(2'd2, 8'h07);
    @(negedge clk);
    check("R8 level 7", {7'b0, irq_req}, 8'h01);
    wr(2'd0, 8'h00);
    @(negedge clk);
    check("R5 req falls after clear", {7'b0, irq_req}, 8'h00);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule